// File: doc/BRIEF.md
# SPI error flag controller

This block holds the control bits and the two error flags of an SPI peripheral: the mode-fault flag, raised when a master sees its slave-select pulled active, and the overrun flag, raised when a byte completes while the previous one is still unread. A small register bus with separate read and write strobes reaches three registers: status, control and data. The data register itself lives with the shift engine. This block only observes reads of it, so that it can follow the overrun clearing sequence.

A mode fault drops the enable and master bits at once. Software cannot set them again until it has cleared the fault. It does that with two steps: first a status access, then a control write. An overrun freezes the receive buffer until software reads the data register and then the status register. An error interrupt combines both flags with an interrupt-enable bit. The slave-select pin is resynchronised before it is used, and the asynchronous reset is released through a two-flop synchroniser.

Top module: `spi_errflag_ctrl`

## Requirements
- R1: The fault condition is present when the master bit is 1 and the selected slave-select level is 0. When control bit 2 (software select) is 1, the level is control bit 3; otherwise it is the synchronised `nss_in`. The fault condition sets the mode-fault flag on the next edge.
- R2: On the edge that sets the mode-fault flag, enable (control bit 0) and master (control bit 1) both become 0.
- R3: The mode-fault flag clears only through two steps. First, a status register access (address 0, read or write) is made while the flag is set. Second, a later write to the control register (address 1) is made. Data register accesses and control writes without the first step leave the flag set.
- R4: While the mode-fault flag is set, a control write cannot set enable or master, but its other fields (control bits 2 to 4) still take effect. The write that completes the clearing sequence may set enable and master.
- R5: The mode-fault flag never becomes set while the master bit is 0.
- R6: A `rx_done` pulse while `rxne_in` is 1 sets the overrun flag on the next edge.
- R7: `rx_buf_we` is 1 only for a `rx_done` pulse with `rxne_in` at 0 and the overrun flag clear. While the overrun flag is set, no incoming byte updates the buffer.
- R8: The overrun flag clears only through two steps: a data register read (address 2) while the flag is set, then a status register read. A status read alone leaves the flag set.
- R9: `err_irq` is 1 exactly when control bit 4 (error interrupt enable) is 1 and at least one of the two error flags is set.
- R10: After reset, enable, master, both flags, `err_irq` and all control fields are 0.
- R11: `nss_in` passes through two flops. A low level applied before edge k sets the mode-fault flag on edge k+2, and not on edge k+1.
- R12: A new overrun in the same cycle as the status read that would end the clearing sequence wins. The flag stays set and the first step is forgotten.
- R13: A control write in the cycle a mode fault is detected takes its bits 2 to 4, while enable and master end at 0 and the mode-fault flag sets.
- R14: Reading address 0 returns mode-fault in bit 0, overrun in bit 1 and `rxne_in` in bit 2. Reading address 1 returns the control fields in bits 0 to 4. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 status, 1 control, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for status and control |
| nss_in | input | 1 | Slave-select pin, asynchronous |
| rxne_in | input | 1 | Receive buffer not empty, from the shift engine |
| rx_done | input | 1 | One-cycle pulse when a byte has been received |
| spi_en | output | 1 | Interface enable bit |
| spi_master | output | 1 | Master mode bit |
| modf_flag | output | 1 | Mode-fault flag |
| ovr_flag | output | 1 | Overrun flag |
| rx_buf_we | output | 1 | Receive buffer update enable |
| err_irq | output | 1 | Error interrupt |

## Verification
Two pairs of events can land in the same cycle. The first pair is the closing step of a clearing sequence and a fresh occurrence of the error it clears. The bench provokes this for overrun by issuing the status read together with a `rx_done` pulse while `rxne_in` is high. It then checks that the flag stays set and that a further status read alone still does not clear it. The second pair is a control write and a mode fault: the bench writes the control register in the very cycle the fault is detected. It judges the result by enable and master reading 0 while the write's interrupt-enable bit takes hold. A sweep over software-select, software level, pin level and master bit compares the flag against the arithmetic fault condition.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int SB_MODF = 0;
  localparam int SB_OVR  = 1;
  localparam int SB_RXNE = 2;

  typedef struct packed {
    logic errie;  // bit 4
    logic swlvl;  // bit 3
    logic swsel;  // bit 2
    logic mast;   // bit 1
    logic en;     // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_err_sync.sv
module spi_err_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_err_modf.sv
module spi_err_modf
  import spi_err_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  logic  stat_acc,
  input  ctrl_t wr_val,
  input  logic  nss_sync,
  output ctrl_t ctrl_q,
  output logic  modf_q
);
  logic  armed_q, armed_d, modf_d;
  ctrl_t ctrl_d;
  logic  sel_level, fault_cond, modf_clr, ctrl_ce;

  assign sel_level  = ctrl_q.swsel ? ctrl_q.swlvl : nss_sync;
  assign fault_cond = ctrl_q.mast & ~sel_level;
  assign modf_clr   = wr_ctrl & armed_q;
  assign ctrl_ce    = wr_ctrl | fault_cond;

  always_comb begin
    ctrl_d  = ctrl_q;
    modf_d  = modf_q;
    armed_d = armed_q;
    if (wr_ctrl) begin
      ctrl_d = wr_val;
      if (modf_q && !modf_clr) begin
        ctrl_d.en   = ctrl_q.en & wr_val.en;
        ctrl_d.mast = ctrl_q.mast & wr_val.mast;
      end
    end
    if (modf_clr) begin
      modf_d  = 1'b0;
      armed_d = 1'b0;
    end else if (stat_acc && modf_q) begin
      armed_d = 1'b1;
    end
    if (fault_cond) begin
      modf_d      = 1'b1;
      armed_d     = 1'b0;
      ctrl_d.en   = 1'b0;
      ctrl_d.mast = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      modf_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      modf_q  <= modf_d;
      armed_q <= armed_d;
    end
  end

  a_r2_fault_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cond |=> (modf_q && !ctrl_q.en && !ctrl_q.mast));
  a_r3_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_q && !armed_q) |=> modf_q);
  a_r4_bits_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_q && !modf_clr) |=> (!ctrl_q.en && !ctrl_q.mast));
  a_r5_slave_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.mast && !modf_q) |=> !modf_q);
endmodule

// File: rtl/spi_err_ovr.sv
module spi_err_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rxne_in,
  input  logic data_rd,
  input  logic stat_rd,
  output logic ovr_q,
  output logic buf_we
);
  logic armed_q, armed_d, ovr_d;
  logic ovr_set, ovr_clr;

  assign ovr_set = rx_done & rxne_in;
  assign ovr_clr = stat_rd & armed_q & ~ovr_set;
  assign buf_we  = rx_done & ~rxne_in & ~ovr_q;

  always_comb begin
    ovr_d   = ovr_q;
    armed_d = armed_q;
    if (ovr_set) begin
      ovr_d   = 1'b1;
      armed_d = 1'b0;
    end else if (ovr_clr) begin
      ovr_d   = 1'b0;
      armed_d = 1'b0;
    end else if (data_rd && ovr_q) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ovr_q   <= ovr_d;
      armed_q <= armed_d;
    end
  end

  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxne_in) |=> ovr_q);
  a_r8_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !armed_q) |=> ovr_q);
  a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && rx_done && rxne_in) |=> ovr_q);
endmodule

// File: rtl/spi_errflag_ctrl.sv
module spi_errflag_ctrl
  import spi_err_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              nss_in,
  input  logic              rxne_in,
  input  logic              rx_done,
  output logic              spi_en,
  output logic              spi_master,
  output logic              modf_flag,
  output logic              ovr_flag,
  output logic              rx_buf_we,
  output logic              err_irq
);
  logic  rst_sync_n, nss_sync;
  logic  sel_stat, sel_ctrl, sel_data;
  logic  wr_ctrl, stat_acc, stat_rd, data_rd;
  ctrl_t ctrl_q, wr_val;
  logic  modf_q, ovr_q;
  logic  unused_wbits;

  spi_err_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  spi_err_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nss_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(nss_in), .q(nss_sync));

  assign sel_stat = (reg_addr == ADDR_STAT);
  assign sel_ctrl = (reg_addr == ADDR_CTRL);
  assign sel_data = (reg_addr == ADDR_DATA);
  assign wr_ctrl  = reg_wr & sel_ctrl;
  assign stat_acc = (reg_wr | reg_rd) & sel_stat;
  assign stat_rd  = reg_rd & sel_stat;
  assign data_rd  = reg_rd & sel_data;
  assign wr_val   = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign unused_wbits = ^reg_wdata[REG_W-1:CTRL_W];

  spi_err_modf u_modf (
    .clk(clk), .rst_n(rst_sync_n), .wr_ctrl(wr_ctrl), .stat_acc(stat_acc),
    .wr_val(wr_val), .nss_sync(nss_sync), .ctrl_q(ctrl_q), .modf_q(modf_q));

  spi_err_ovr u_ovr (
    .clk(clk), .rst_n(rst_sync_n), .rx_done(rx_done), .rxne_in(rxne_in),
    .data_rd(data_rd), .stat_rd(stat_rd), .ovr_q(ovr_q), .buf_we(rx_buf_we));

  always_comb begin
    reg_rdata = '0;
    if (sel_stat) begin
      reg_rdata[SB_MODF] = modf_q;
      reg_rdata[SB_OVR]  = ovr_q;
      reg_rdata[SB_RXNE] = rxne_in;
    end else if (sel_ctrl) begin
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    end
  end

  assign spi_en     = ctrl_q.en;
  assign spi_master = ctrl_q.mast;
  assign modf_flag  = modf_q;
  assign ovr_flag   = ovr_q;
  assign err_irq    = ctrl_q.errie & (modf_q | ovr_q);

  a_r7_frozen_buffer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(ovr_flag) && ovr_flag |-> !rx_buf_we);
endmodule

// File: tb/spi_errflag_ctrl_tb.sv
module spi_errflag_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       nss_in, rxne_in, rx_done;
  logic       spi_en, spi_master, modf_flag, ovr_flag, rx_buf_we, err_irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_errflag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nss_in(nss_in), .rxne_in(rxne_in),
    .rx_done(rx_done), .spi_en(spi_en), .spi_master(spi_master), .modf_flag(modf_flag),
    .ovr_flag(ovr_flag), .rx_buf_we(rx_buf_we), .err_irq(err_irq));

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd3; reg_wdata = 8'h00;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    bus(1'b1, 1'b0, 2'd1, d);
  endtask

  task automatic stat_rd();
    bus(1'b0, 1'b1, 2'd0, 8'h00);
  endtask

  task automatic data_rd();
    bus(1'b0, 1'b1, 2'd2, 8'h00);
  endtask

  task automatic byte_in(input logic full);
    rxne_in = full; rx_done = 1'b1;
    tick();
    rx_done = 1'b0; rxne_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd3; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    nss_in = 1'b1; rxne_in = 1'b0; rx_done = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R10 reset state
    chk("R10", "en/mst/modf/ovr/irq", {3'b0, spi_en, spi_master, modf_flag, ovr_flag, err_irq}, 8'h00);
    reg_addr = 2'd1; #1;
    chk("R10", "ctrl readback", reg_rdata, 8'h00);
    reg_addr = 2'd3;

    // R1, R14: master with pin high, no fault
    wr_ctrl(8'h13);
    chk("R1", "en/mst/modf pin high", {5'b0, spi_en, spi_master, modf_flag}, 8'h06);
    reg_addr = 2'd1; #1;
    chk("R14", "ctrl readback", reg_rdata, 8'h13);
    reg_addr = 2'd3;

    // R11, R2, R9: pin low, latency of the synchroniser
    nss_in = 1'b0;
    idle(2);
    chk("R11", "modf one edge early", {7'b0, modf_flag}, 8'h00);
    tick();
    chk("R11", "modf after sync", {7'b0, modf_flag}, 8'h01);
    chk("R2", "en/mst after fault", {6'b0, spi_en, spi_master}, 8'h00);
    chk("R9", "irq on modf", {7'b0, err_irq}, 8'h01);
    nss_in = 1'b1;
    idle(2);

    // R4: blocked bits, rest of write applies
    wr_ctrl(8'h03);
    chk("R4", "en/mst blocked", {6'b0, spi_en, spi_master}, 8'h00);
    chk("R4", "errie cleared by write", {7'b0, err_irq}, 8'h00);
    chk("R3", "ctrl write alone keeps modf", {7'b0, modf_flag}, 8'h01);
    data_rd();
    wr_ctrl(8'h10);
    chk("R3", "data read does not arm", {7'b0, modf_flag}, 8'h01);
    reg_addr = 2'd0; #1;
    chk("R14", "status modf bit", reg_rdata, 8'h01);
    stat_rd();
    wr_ctrl(8'h13);
    chk("R3", "read+write clears modf", {7'b0, modf_flag}, 8'h00);
    chk("R4", "clearing write restores bits", {6'b0, spi_en, spi_master}, 8'h03);

    // R3: status write also arms
    nss_in = 1'b0;
    idle(3);
    chk("R1", "second fault", {7'b0, modf_flag}, 8'h01);
    nss_in = 1'b1;
    idle(2);
    bus(1'b1, 1'b0, 2'd0, 8'hFF);
    wr_ctrl(8'h00);
    chk("R3", "status write arms clear", {7'b0, modf_flag}, 8'h00);

    // R1, R5 sweep over select mode, software level, pin level, master bit
    for (int v = 0; v < 16; v++) begin
      logic m, ssm, ssi, pin, exp_f;
      m = v[0]; ssm = v[1]; ssi = v[2]; pin = v[3];
      exp_f = m & (ssm ? ~ssi : ~pin);
      nss_in = pin;
      idle(3);
      wr_ctrl({4'b0, ssi, ssm, m, 1'b1});
      tick();
      chk(m ? "R1" : "R5", $sformatf("modf combo %0d", v), {7'b0, modf_flag}, {7'b0, exp_f});
      chk("R2", $sformatf("mst combo %0d", v), {7'b0, spi_master}, {7'b0, m & ~exp_f});
      if (exp_f) stat_rd();
      wr_ctrl(8'h00);
      nss_in = 1'b1;
    end
    idle(2);

    // R13: control write in the fault cycle
    nss_in = 1'b0;
    idle(3);
    wr_ctrl(8'h03);
    wr_ctrl(8'h13);
    chk("R13", "modf/en/mst", {5'b0, modf_flag, spi_en, spi_master}, 8'h04);
    chk("R13", "errie from write", {7'b0, err_irq}, 8'h01);
    nss_in = 1'b1;
    idle(2);
    stat_rd();
    wr_ctrl(8'h00);
    chk("R3", "cleared after R13", {7'b0, modf_flag}, 8'h00);

    // R7, R6: overrun
    rxne_in = 1'b0; rx_done = 1'b1; #1;
    chk("R7", "buffer update on empty", {7'b0, rx_buf_we}, 8'h01);
    tick(); rx_done = 1'b0;
    chk("R6", "no overrun on empty", {7'b0, ovr_flag}, 8'h00);
    rxne_in = 1'b1; rx_done = 1'b1; #1;
    chk("R7", "no update when full", {7'b0, rx_buf_we}, 8'h00);
    tick(); rx_done = 1'b0; rxne_in = 1'b0;
    chk("R6", "overrun set", {7'b0, ovr_flag}, 8'h01);
    rx_done = 1'b1; #1;
    chk("R7", "frozen during overrun", {7'b0, rx_buf_we}, 8'h00);
    tick(); rx_done = 1'b0;
    reg_addr = 2'd0; #1;
    chk("R14", "status ovr bit", reg_rdata, 8'h02);

    // R9 with overrun only
    chk("R9", "irq off when disabled", {7'b0, err_irq}, 8'h00);
    wr_ctrl(8'h10);
    chk("R9", "irq on ovr", {7'b0, err_irq}, 8'h01);

    // R8: clearing order
    stat_rd();
    chk("R8", "status read alone", {7'b0, ovr_flag}, 8'h01);
    data_rd();
    chk("R8", "data read alone", {7'b0, ovr_flag}, 8'h01);
    stat_rd();
    chk("R8", "data then status clears", {7'b0, ovr_flag}, 8'h00);
    chk("R9", "irq drops", {7'b0, err_irq}, 8'h00);

    // R12: new overrun in the closing cycle
    byte_in(1'b1);
    data_rd();
    reg_rd = 1'b1; reg_addr = 2'd0; rxne_in = 1'b1; rx_done = 1'b1;
    tick();
    reg_rd = 1'b0; reg_addr = 2'd3; rxne_in = 1'b0; rx_done = 1'b0;
    chk("R12", "set wins over clear", {7'b0, ovr_flag}, 8'h01);
    stat_rd();
    chk("R12", "first step forgotten", {7'b0, ovr_flag}, 8'h01);
    data_rd();
    stat_rd();
    chk("R8", "clears after restart", {7'b0, ovr_flag}, 8'h00);

    rxne_in = 1'b1; #1;
    reg_addr = 2'd0; #1;
    chk("R14", "status rxne bit", reg_rdata, 8'h04);
    rxne_in = 1'b0; reg_addr = 2'd3;
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule